// File: doc/BRIEF.md
# Low-Resolution Playfield Serializer

This block turns a small set of stored background bits into a per-pixel bit stream for one scanline of 160 pixel clocks. Twenty bits are held across three graphics registers. Each bit is widened to four pixel clocks, so the left half of the line shows all twenty bits. The right half either shows them again in the same order, or shows them back to front, so that a symmetric background can be drawn from half the storage.

A processor writes the graphics and control registers through a simple strobe, address and data port. The video timing logic presents the current horizontal position and a visible-area flag on every pixel clock. The block returns one registered "background on" bit. Register writes never split a bit: the value of each four-clock bit is captured on that bit's first pixel clock. Colour, priority and overlap detection are handled elsewhere.

Top module: `pfSerializer`

## Requirements
- R1: A write (wrEn high) with wrAddr 0, 1 or 2 loads graphics register 0, 1 or 2 from wrData. wrAddr 3 loads the mode register. Only one register is loaded per write.
- R2: For a position x below 160, the pixel belongs to line bit x/4 (0..39). Bits 0..19 form the left half and bits 20..39 form the right half.
- R3: Left-half bit k takes its value from sequence element k. The 20-element sequence is register 0 bits 4,5,6,7, then register 1 bits 7 down to 0, then register 2 bits 0 up to 7.
- R4: With mode bit 0 clear, right-half bit 20+j shows sequence element j (repeat).
- R5: With mode bit 0 set, right-half bit 20+j shows sequence element 19-j (mirror).
- R6: pfOn in the cycle after position x is presented gives the value for pixel x.
- R7: Every line bit takes its value from the registers as they stood before its first pixel clock, that is, the clock edge where x mod 4 is 0. A write in any cycle only affects bits that start in a later cycle.
- R8: When visible is low in the cycle that presents x, pfOn is 0 in the following cycle.
- R9: Positions of 160 and above give pfOn 0 in the following cycle, even when visible is high.
- R10: Bits 3..0 of graphics register 0 and bits 7..1 of the mode register are ignored.
- R11: After reset all registers are zero and pfOn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixX | input | 8 | Horizontal pixel position |
| visible | input | 1 | High inside the visible area |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0..2 graphics, 3 mode |
| wrData | input | 8 | Register write data |
| pfOn | output | 1 | Registered background bit for the previous position |

## Verification
The bench uses the default parameters: four pixel clocks per bit, a 4+8+8 register layout and an 8-bit position. With these values a whole 228-position line, including blanking, can be swept in a few hundred cycles. This puts both halves, both modes, writes at and between bit boundaries, and positions past the line end within reach. The bench's reference model rebuilds the bit sequence from the register contents and compares pfOn on every clock.

// File: rtl/pfPkg.sv
package pfPkg;
  // Defaults shared by the control and datapath modules
  localparam int NIB_W_D        = 4;
  localparam int BYTE_W_D       = 8;
  localparam int PIX_PER_BIT_D  = 4;
  localparam int X_W_D          = 8;
  localparam int STORED_BITS_D  = NIB_W_D + 2 * BYTE_W_D;
  localparam int SLOT_W         = $clog2(STORED_BITS_D);
  localparam int NUM_REGS       = 4;

  // Strobes from the position/write decoder to the datapath
  typedef struct packed {
    logic                bitStart;   // first pixel clock of a line bit
    logic                inLine;     // position lies inside the line
    logic                rightHalf;  // position lies in the right half
    logic                visible;    // visible-area flag passed through
    logic [SLOT_W-1:0]   slot;       // bit index folded into one half
    logic [NUM_REGS-1:0] loadSel;    // one-hot register load
  } pfStrobes_t;
endpackage

// File: rtl/pfCtrl.sv
module pfCtrl
  import pfPkg::*;
#(
  parameter int PIX_PER_BIT = PIX_PER_BIT_D,
  parameter int STORED_BITS = STORED_BITS_D,
  parameter int X_W         = X_W_D
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [X_W-1:0] pixX,
  input  logic           visible,
  input  logic           wrEn,
  input  logic [1:0]     wrAddr,
  output pfStrobes_t     strb
);
  localparam int LINE_BITS   = 2 * STORED_BITS;
  localparam int LINE_PIXELS = LINE_BITS * PIX_PER_BIT;

  logic [X_W-1:0] bitIdx;
  logic [X_W-1:0] slotWide;
  logic [X_W-1:0] phase;

  always_comb begin
    bitIdx   = pixX / X_W'(PIX_PER_BIT);
    phase    = pixX % X_W'(PIX_PER_BIT);
    strb.inLine    = (32'(pixX) < LINE_PIXELS);
    strb.rightHalf = (32'(bitIdx) >= STORED_BITS);
    strb.bitStart  = (phase == '0);
    strb.visible   = visible;
    slotWide = strb.rightHalf ? (bitIdx - X_W'(STORED_BITS)) : bitIdx;
    strb.slot = strb.inLine ? slotWide[SLOT_W-1:0] : '0;
  end

  // Write decode: one load line per register
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_load
    assign strb.loadSel[r] = wrEn && (wrAddr == 2'(r));
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.loadSel) && (wrEn == (strb.loadSel != '0))); // R1
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.inLine |-> (32'(strb.slot) < STORED_BITS)); // R2
endmodule

// File: rtl/pfDatapath.sv
module pfDatapath
  import pfPkg::*;
#(
  parameter int NIB_W       = NIB_W_D,
  parameter int BYTE_W      = BYTE_W_D,
  parameter int STORED_BITS = STORED_BITS_D
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobes_t        strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              pfOn
);
  localparam int MID_BASE = NIB_W;
  localparam int END_BASE = NIB_W + BYTE_W;

  logic [NIB_W-1:0]       gNib;
  logic [BYTE_W-1:0]      gMid;
  logic [BYTE_W-1:0]      gEnd;
  logic                   reflectQ;
  logic [STORED_BITS-1:0] seq;
  logic [SLOT_W-1:0]      effSlot;
  logic                   pick;
  logic                   heldBit;

  // Register file: only the upper nibble of register 0 and bit 0 of the
  // mode register are kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gNib     <= '0;
      gMid     <= '0;
      gEnd     <= '0;
      reflectQ <= 1'b0;
    end else begin
      if (strb.loadSel[0]) gNib     <= wrData[BYTE_W-1 -: NIB_W];
      if (strb.loadSel[1]) gMid     <= wrData;
      if (strb.loadSel[2]) gEnd     <= wrData;
      if (strb.loadSel[3]) reflectQ <= wrData[0];
    end
  end

  // Assemble the 20-element display sequence
  for (genvar k = 0; k < NIB_W; k++) begin : g_nib
    assign seq[k] = gNib[k];
  end
  for (genvar k = 0; k < BYTE_W; k++) begin : g_bytes
    assign seq[MID_BASE + k] = gMid[BYTE_W-1-k];
    assign seq[END_BASE + k] = gEnd[k];
  end

  always_comb begin
    effSlot = (strb.rightHalf && reflectQ)
            ? (SLOT_W'(STORED_BITS - 1) - strb.slot) : strb.slot;
    pick = seq[effSlot];
  end

  // Capture each bit's value on its first pixel clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldBit <= 1'b0;
      pfOn    <= 1'b0;
    end else begin
      if (strb.bitStart && strb.inLine) heldBit <= pick;
      pfOn <= strb.visible && strb.inLine
              && ((strb.bitStart) ? pick : heldBit);
    end
  end

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !strb.visible |=> !pfOn); // R8
  AST_PAST_LINE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inLine |=> !pfOn); // R9
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pfOn && !strb.bitStart && strb.visible && strb.inLine) |=> pfOn); // R7
endmodule

// File: rtl/pfSerializer.sv
module pfSerializer
  import pfPkg::*;
#(
  parameter int NIB_W       = NIB_W_D,
  parameter int BYTE_W      = BYTE_W_D,
  parameter int PIX_PER_BIT = PIX_PER_BIT_D,
  parameter int X_W         = X_W_D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [X_W-1:0]    pixX,
  input  logic              visible,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic              pfOn
);
  localparam int STORED_BITS = NIB_W + 2 * BYTE_W;

  pfStrobes_t strb;

  pfCtrl #(
    .PIX_PER_BIT (PIX_PER_BIT),
    .STORED_BITS (STORED_BITS),
    .X_W         (X_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pixX    (pixX),
    .visible (visible),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strb    (strb)
  );

  pfDatapath #(
    .NIB_W       (NIB_W),
    .BYTE_W      (BYTE_W),
    .STORED_BITS (STORED_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .pfOn   (pfOn)
  );

  AST_RESET_DARK: assert property (@(posedge clk)
    !rstN |=> !pfOn); // R11
endmodule

// File: tb/pfSerializer_tb.sv
module pfSerializer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pixX = '0;
  logic       visible = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pfOn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  int mReg[4] = '{0, 0, 0, 0};
  bit heldM = 0;
  bit expQ = 0;
  bit havePrev = 0;
  string tagPrev = "";

  always #2 clk = ~clk;

  pfSerializer u_dut (
    .clk(clk), .rstN(rstN), .pixX(pixX), .visible(visible),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pfOn(pfOn)
  );

  // R3: sequence element j from the register contents
  function automatic bit seqBit(int j);
    if (j < 4)  return bit'((mReg[0] >> (4 + j)) & 1);
    if (j < 12) return bit'((mReg[1] >> (7 - (j - 4))) & 1);
    return bit'((mReg[2] >> (j - 12)) & 1);
  endfunction

  // R4 / R5: line bit b (0..39) in the current mode
  function automatic bit lineBit(int b);
    int j;
    if (b < 20) return seqBit(b);
    j = b - 20;
    if ((mReg[3] & 1) != 0) j = 19 - j;
    return seqBit(j);
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pfOn actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick(int x, bit vis, bit we, int addr, int data, string tag);
    @(negedge clk);
    if (havePrev) check(pfOn, expQ, tagPrev);
    pixX = 8'(x); visible = vis; wrEn = we;
    wrAddr = 2'(addr); wrData = 8'(data);
    if ((x % 4) == 0 && x < 160) heldM = lineBit(x / 4);
    expQ = vis && (x < 160) && heldM;
    if (we) begin
      if (addr == 0) mReg[0] = data & 8'hF0;   // R10
      else if (addr == 3) mReg[3] = data & 1;  // R10
      else mReg[addr] = data;
    end
    havePrev = 1; tagPrev = tag;
  endtask

  task automatic wr(int addr, int data, string tag);
    tick(200, 1'b0, 1'b1, addr, data, tag);
  endtask

  task automatic runLine(string tag, int wrAt, int addr, int data);
    for (int x = 0; x < 228; x++)
      tick(x, x < 160, x == wrAt, addr, data, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(pfOn, 1'b0, "R11 reset output");
    @(negedge clk); rstN = 1'b1;
    runLine("R11 cleared registers", -1, 0, 0);

    wr(0, 8'hA0, "R1 write reg0");
    wr(1, 8'h5C, "R1 write reg1");
    wr(2, 8'h93, "R1 write reg2");
    wr(3, 8'h00, "R1 write mode");
    runLine("R2 R3 R4 R6 repeat line", -1, 0, 0);
    wr(3, 8'h01, "R1 mode mirror");
    runLine("R5 mirror line", -1, 0, 0);
    wr(3, 8'hFE, "R10 mode upper bits");
    runLine("R10 mode bits 7..1 ignored", -1, 0, 0);
    wr(0, 8'h0F, "R10 low nibble");
    runLine("R10 reg0 bits 3..0 ignored", -1, 0, 0);

    wr(0, 8'h50, "R1 setup");
    wr(1, 8'h00, "R1 setup");
    wr(2, 8'hFF, "R1 setup");
    runLine("R7 write mid-bit", 6, 1, 8'hFF);
    runLine("R7 write on bit start", 8, 2, 8'h0F);
    runLine("R7 mode switch mid-line", 90, 3, 8'h01);
    runLine("R7 mode switch on boundary", 100, 3, 8'h00);

    for (int x = 0; x < 228; x++)
      tick(x, (x < 160) && !(x >= 41 && x < 63), 1'b0, 0, 0,
           "R8 blank inside line");
    wr(0, 8'hF0, "R1 setup"); wr(1, 8'hFF, "R1 setup");
    wr(2, 8'hFF, "R1 setup");
    for (int x = 150; x < 256; x++)
      tick(x, 1'b1, 1'b0, 0, 0, "R9 past line end");
    tick(200, 1'b0, 1'b0, 0, 0, "R9 flush");

    @(negedge clk);
    check(pfOn, expQ, tagPrev);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule